// File: doc/BRIEF.md
# Parity-Partitioned Shared Memory Port Controller

This controller connects one processor to one port of a two-ported shared memory. It serves a single access at a time. Each address has a fixed direction for each side, set by the address's lowest bit. The side served by the controller is chosen by a parameter. On the host side, odd addresses may only be written and even addresses may only be read. On the signal-processor side the rule is mirrored. Because of this split, the two processors can never write the same cell. A request that breaks the rule is refused: it raises a one-cycle error flag and never reaches the memory.

Requests arrive over a valid/ready handshake on a 32-bit data bus. The memory port is 16 bits wide. On writes, only the low half of the write data goes to the memory. On reads, the upper half of the returned word is zero.

The controller never starts an access while the port's active-low busy input is asserted. If busy asserts during an access, the controller holds every memory signal steady and stays in the access until busy clears. An access that meets no busy completes with fixed timing:
- The request is accepted on edge 0.
- Chip enable goes low after edge 1.
- The response is valid after edge 2.
- The controller is ready again after edge 3.

Top module: `dpm_side_gate`

## Requirements
- R1: With SIDE=0 (host side), a write is legal only when address bit 0 is 1, and a read is legal only when address bit 0 is 0.
- R2: With SIDE=1 (signal-processor side), a write is legal only when address bit 0 is 0, and a read is legal only when address bit 0 is 1.
- R3: After a legal request is accepted, memCeN stays high while memBusyN is sampled low. memCeN goes low only after a clock edge at which memBusyN was sampled high.
- R4: During a read access:
  - memCeN is 0, memOeN is 0, memDrive is 0, and memAddr equals the request address.
  - The response carries memDin (as sampled at the edge that ends the access) in bits 15:0 and zero in bits 31:16.
- R5: During a write access:
  - memCeN is 0, memOeN is 1, memDrive is 1, and memDout equals bits 15:0 of the write data. Bits 31:16 of the write data have no effect.
  - The response data of a write is zero.
- R6: An illegal request is consumed in one cycle. parityErr is high for exactly the one cycle after the accepting edge. memCeN stays high throughout.
- R7: reqReady is high only when the controller is idle. rspValid is high for exactly one cycle per legal request. reqReady returns high in the cycle after rspValid.
- R8: If memBusyN is sampled low at the edge that would end an access, the access is extended by a cycle. memCeN, memOeN, memDrive and memAddr are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address in shared memory |
| reqWData | input | HOST_W | Write data (low MEM_W bits used) |
| reqReady | output | 1 | Controller idle, request taken when valid |
| rspValid | output | 1 | One-cycle completion strobe of a legal request |
| rspRData | output | HOST_W | Read data, zero-extended; zero for writes |
| parityErr | output | 1 | One-cycle flag for a refused request |
| memCeN | output | 1 | Memory chip enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memAddr | output | ADDR_W | Memory address |
| memDout | output | MEM_W | Data toward memory |
| memDrive | output | 1 | Enables the data pins toward memory |
| memDin | input | MEM_W | Data from memory |
| memBusyN | input | 1 | Port busy from memory arbitration, active low |

## Verification
The bench sweeps both side settings over every combination of direction, low addresses and the top addresses. This covers the parity boundary in both directions: a controller with the rule inverted, or with the same rule on both sides, would issue the forbidden access or refuse the legal one. Each legal request is run with a different number of busy cycles before the access, and some have busy asserted in the middle of the access. A controller that ignored busy would lower chip enable too early or finish one cycle too soon. Read responses are compared against an arithmetic memory model with the upper half checked for zero. Write data carries a distinct upper half, so a wrong slice or a missing zero-extension shows up in memDout or rspRData.

// File: rtl/dpm_side_gate_pkg.sv
package dpm_side_gate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ACCESS = 2'd2,
    ST_DONE   = 2'd3
  } gateState_t;

  typedef struct packed {
    logic capture;   // latch request fields
    logic latchRd;   // latch read data at end of access
    logic accessOn;  // memory access cycle
    logic rspOn;     // response strobe
  } gateStrobe_t;
endpackage

// File: rtl/dpm_side_gate_ctrl.sv
module dpm_side_gate_ctrl
  import dpm_side_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqLegal,
  input  logic        memBusyN,
  output logic        reqReady,
  output logic        parityErr,
  output gateStrobe_t strobe
);
  gateState_t state, stateNext;
  logic errQ, errNext;

  always_comb begin
    stateNext = state;
    errNext   = 1'b0;
    strobe    = '0;
    reqReady  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          if (reqLegal) begin
            strobe.capture = 1'b1;
            stateNext      = ST_WAIT;
          end else begin
            errNext = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (memBusyN) stateNext = ST_ACCESS;
      end
      ST_ACCESS: begin
        strobe.accessOn = 1'b1;
        if (memBusyN) begin
          strobe.latchRd = 1'b1;
          stateNext      = ST_DONE;
        end
      end
      ST_DONE: begin
        strobe.rspOn = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      errQ  <= 1'b0;
    end else begin
      state <= stateNext;
      errQ  <= errNext;
    end
  end

  assign parityErr = errQ;
endmodule

// File: rtl/dpm_side_gate_dp.sv
module dpm_side_gate_dp
  import dpm_side_gate_pkg::*;
#(
  parameter bit SIDE   = 1'b0,
  parameter int ADDR_W = 11,
  parameter int MEM_W  = 16,
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [HOST_W-1:0] reqWData,
  input  gateStrobe_t       strobe,
  input  logic [MEM_W-1:0]  memDin,
  output logic              reqLegal,
  output logic [HOST_W-1:0] rspRData,
  output logic              memCeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [MEM_W-1:0]  memDout,
  output logic              memDrive
);
  localparam int  PAD_W  = HOST_W - MEM_W;
  localparam logic WR_PAR = SIDE ? 1'b0 : 1'b1;  // parity allowed for writes

  logic              wrQ;
  logic [ADDR_W-1:0] addrQ;
  logic [MEM_W-1:0]  wdQ;
  logic [MEM_W-1:0]  rdQ;

  assign reqLegal = reqWrite ? (reqAddr[0] == WR_PAR) : (reqAddr[0] != WR_PAR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrQ   <= 1'b0;
      addrQ <= '0;
      wdQ   <= '0;
      rdQ   <= '0;
    end else begin
      if (strobe.capture) begin
        wrQ   <= reqWrite;
        addrQ <= reqAddr;
        wdQ   <= reqWData[MEM_W-1:0];
      end
      if (strobe.latchRd) rdQ <= wrQ ? '0 : memDin;
    end
  end

  assign memCeN   = ~strobe.accessOn;
  assign memOeN   = ~(strobe.accessOn & ~wrQ);
  assign memDrive = strobe.accessOn & wrQ;
  assign memAddr  = addrQ;
  assign memDout  = wdQ;
  assign rspRData = {{PAD_W{1'b0}}, rdQ};
endmodule

// File: rtl/dpm_side_gate.sv
module dpm_side_gate
  import dpm_side_gate_pkg::*;
#(
  parameter bit SIDE   = 1'b0,
  parameter int ADDR_W = 11,
  parameter int MEM_W  = 16,
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [HOST_W-1:0] reqWData,
  output logic              reqReady,
  output logic              rspValid,
  output logic [HOST_W-1:0] rspRData,
  output logic              parityErr,
  output logic              memCeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [MEM_W-1:0]  memDout,
  output logic              memDrive,
  input  logic [MEM_W-1:0]  memDin,
  input  logic              memBusyN
);
  gateStrobe_t strobe;
  logic        reqLegal;

  dpm_side_gate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLegal(reqLegal),
    .memBusyN(memBusyN), .reqReady(reqReady), .parityErr(parityErr),
    .strobe(strobe)
  );

  dpm_side_gate_dp #(
    .SIDE(SIDE), .ADDR_W(ADDR_W), .MEM_W(MEM_W), .HOST_W(HOST_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWData(reqWData), .strobe(strobe), .memDin(memDin),
    .reqLegal(reqLegal), .rspRData(rspRData), .memCeN(memCeN),
    .memOeN(memOeN), .memAddr(memAddr), .memDout(memDout),
    .memDrive(memDrive)
  );

  assign rspValid = strobe.rspOn;
endmodule

// File: rtl/dpm_side_gate_chk.sv
module dpm_side_gate_chk #(
  parameter bit SIDE   = 1'b0,
  parameter int ADDR_W = 11,
  parameter int MEM_W  = 16,
  parameter int HOST_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [HOST_W-1:0] rspRData,
  input logic              parityErr,
  input logic              memCeN,
  input logic              memOeN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memDrive,
  input logic              memBusyN
);
  localparam logic WR_PAR = SIDE ? 1'b0 : 1'b1;

  // R1 R2: any memory access obeys the side's parity rule
  p_parity_dir_r1: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> (memDrive ? (memAddr[0] == WR_PAR) : (memAddr[0] != WR_PAR)));
  p_parity_side_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && memDrive) |-> (memAddr[0] == (SIDE ? 1'b0 : 1'b1)));

  // R3: access begins only after busy sampled inactive
  p_busy_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCeN) |-> $past(memBusyN));

  // R4 R5: output enable opposite to data drive during access
  p_oe_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !memDrive) |-> !memOeN);
  p_oe_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && memDrive) |-> memOeN);
  p_rsp_pad_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspRData[HOST_W-1:MEM_W] == '0));

  // R6: refused request touches nothing
  p_err_noacc_r6: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> (memCeN && !rspValid));

  // R7: handshake
  p_ready_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN || rspValid) |-> !reqReady);
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  // R8: hold during busy in access
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !memBusyN) |=> (!memCeN && $stable(memAddr) && $stable(memOeN)
                                 && $stable(memDrive)));
endmodule

bind dpm_side_gate dpm_side_gate_chk #(
  .SIDE(SIDE), .ADDR_W(ADDR_W), .MEM_W(MEM_W), .HOST_W(HOST_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .rspRData(rspRData), .parityErr(parityErr), .memCeN(memCeN),
  .memOeN(memOeN), .memAddr(memAddr), .memDrive(memDrive),
  .memBusyN(memBusyN)
);

// File: tb/sim_dpm_side_gate.sv
module sim_dpm_side_gate;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 11;
  localparam int MEM_W  = 16;
  localparam int HOST_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              reqValid [2];
  logic              reqWrite [2];
  logic [ADDR_W-1:0] reqAddr  [2];
  logic [HOST_W-1:0] reqWData [2];
  logic              reqReady [2];
  logic              rspValid [2];
  logic [HOST_W-1:0] rspRData [2];
  logic              parityErr[2];
  logic              memCeN   [2];
  logic              memOeN   [2];
  logic [ADDR_W-1:0] memAddr  [2];
  logic [MEM_W-1:0]  memDout  [2];
  logic              memDrive [2];
  logic [MEM_W-1:0]  memDin   [2];
  logic              memBusyN [2];

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  function automatic logic [MEM_W-1:0] mdl(input logic [ADDR_W-1:0] a);
    return MEM_W'({5'b0, a} * 16'd37 + 16'h1234);
  endfunction

  assign memDin[0] = (!memCeN[0] && !memOeN[0]) ? mdl(memAddr[0]) : 16'hFFFF;
  assign memDin[1] = (!memCeN[1] && !memOeN[1]) ? mdl(memAddr[1]) : 16'hFFFF;

  dpm_side_gate #(.SIDE(1'b0), .ADDR_W(ADDR_W), .MEM_W(MEM_W), .HOST_W(HOST_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[0]), .reqWrite(reqWrite[0]),
    .reqAddr(reqAddr[0]), .reqWData(reqWData[0]), .reqReady(reqReady[0]),
    .rspValid(rspValid[0]), .rspRData(rspRData[0]), .parityErr(parityErr[0]),
    .memCeN(memCeN[0]), .memOeN(memOeN[0]), .memAddr(memAddr[0]),
    .memDout(memDout[0]), .memDrive(memDrive[0]), .memDin(memDin[0]),
    .memBusyN(memBusyN[0]));

  dpm_side_gate #(.SIDE(1'b1), .ADDR_W(ADDR_W), .MEM_W(MEM_W), .HOST_W(HOST_W)) u1 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[1]), .reqWrite(reqWrite[1]),
    .reqAddr(reqAddr[1]), .reqWData(reqWData[1]), .reqReady(reqReady[1]),
    .rspValid(rspValid[1]), .rspRData(rspRData[1]), .parityErr(parityErr[1]),
    .memCeN(memCeN[1]), .memOeN(memOeN[1]), .memAddr(memAddr[1]),
    .memDout(memDout[1]), .memDrive(memDrive[1]), .memDin(memDin[1]),
    .memBusyN(memBusyN[1]));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReq(input int s, input bit wr, input logic [ADDR_W-1:0] a,
                       input logic [HOST_W-1:0] wd, input int busyCycles,
                       input bit midBusy);
    bit legal;
    logic [HOST_W-1:0] expRsp;
    string rtag;
    rtag  = (s == 0) ? "R1" : "R2";
    legal = wr ? (a[0] != 1'(s)) : (a[0] == 1'(s));
    chk(reqReady[s] == 1'b1, "R7 ready idle", 32'(reqReady[s]), 1);
    reqValid[s] = 1'b1; reqWrite[s] = wr; reqAddr[s] = a; reqWData[s] = wd;
    memBusyN[s] = (busyCycles == 0);
    step();
    reqValid[s] = 1'b0;
    if (!legal) begin
      chk(parityErr[s] == 1'b1, {rtag, " R6 refuse err"}, 32'(parityErr[s]), 1);
      chk(memCeN[s] == 1'b1, "R6 no access", 32'(memCeN[s]), 1);
      step();
      chk(parityErr[s] == 1'b0 && memCeN[s] == 1'b1 && rspValid[s] == 1'b0,
          "R6 err one cycle", {29'b0, parityErr[s], memCeN[s], rspValid[s]}, 32'b010);
      memBusyN[s] = 1'b1;
      return;
    end
    chk(parityErr[s] == 1'b0 && reqReady[s] == 1'b0 && memCeN[s] == 1'b1,
        {rtag, " legal accepted"}, {29'b0, parityErr[s], reqReady[s], memCeN[s]}, 32'b001);
    for (int i = 0; i < busyCycles; i++) begin
      step();
      chk(memCeN[s] == 1'b1, "R3 wait on busy", 32'(memCeN[s]), 1);
    end
    memBusyN[s] = 1'b1;
    step();
    for (int k = 0; k < (midBusy ? 2 : 1); k++) begin
      chk(memCeN[s] == 1'b0 && memAddr[s] == a, k == 0 ? "R3 access starts" : "R8 held",
          {memCeN[s], 20'b0, memAddr[s]}, {21'b0, a});
      if (wr)
        chk(memOeN[s] == 1'b1 && memDrive[s] == 1'b1 && memDout[s] == wd[15:0],
            "R5 write pins", {memOeN[s], memDrive[s], 14'b0, memDout[s]},
            {2'b11, 14'b0, wd[15:0]});
      else
        chk(memOeN[s] == 1'b0 && memDrive[s] == 1'b0, "R4 read pins",
            {30'b0, memOeN[s], memDrive[s]}, 0);
      if (midBusy && k == 0) begin
        memBusyN[s] = 1'b0;
        step();
        memBusyN[s] = 1'b1;
      end
    end
    step();
    expRsp = wr ? '0 : {16'h0, mdl(a)};
    chk(rspValid[s] == 1'b1 && memCeN[s] == 1'b1, "R7 rsp strobe",
        {30'b0, rspValid[s], memCeN[s]}, 32'b11);
    chk(rspRData[s] == expRsp, wr ? "R5 write rsp zero" : "R4 read data",
        rspRData[s], expRsp);
    step();
    chk(rspValid[s] == 1'b0 && reqReady[s] == 1'b1, "R7 back to idle",
        {30'b0, rspValid[s], reqReady[s]}, 32'b01);
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      reqValid[s] = 1'b0; reqWrite[s] = 1'b0; reqAddr[s] = '0;
      reqWData[s] = '0; memBusyN[s] = 1'b1;
    end
    repeat (3) @(negedge clk);
    for (int s = 0; s < 2; s++)
      chk(reqReady[s] && memCeN[s] && memOeN[s] && !rspValid[s] && !parityErr[s]
          && !memDrive[s], "R7 reset state",
          {26'b0, reqReady[s], memCeN[s], memOeN[s], rspValid[s], parityErr[s], memDrive[s]},
          32'b111000);
    rstN = 1'b1;
    step();
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n < 18; n++) begin
        for (int w = 0; w < 2; w++) begin
          logic [ADDR_W-1:0] a;
          a = (n < 16) ? ADDR_W'(n) : ADDR_W'(2046 + (n - 16));
          doReq(s, w[0], a, {16'hBEEF ^ 16'(a), 16'h1000 + 16'(a) + 16'(w * 16'h0300)},
                n % 3, n[2]);
        end
      end
    end
    finished = 1'b1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (100000) @(posedge clk);
        nTests++;
        nFail++;
        $display("FAIL watchdog expired actual=hang expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule